// File: doc/BRIEF.md
# Dual-Port Test-and-Set Lock Monitor

This block holds a small word-addressed memory shared by two requesters and gives each of them plain reads, plain writes and an atomic test-and-set. A test-and-set takes a lock on one word and reads its old value. It stores the requester's value only if the old value is zero, then frees the word. Either way the old value goes back to the requester. A requester that asks for a word the other side already holds, or asks in the same cycle and loses, sees a busy indication. The attempt is dropped and must be retried later.

Every operation is a single-cycle request, taken only while the port's engine is idle. Each operation returns the word's value as it stood when the request was accepted, or at the read step for a test-and-set. Each signals completion with a one-cycle done pulse. Plain reads and writes are never locked out. Only competing test-and-set requests to a held word are refused.

Top module: `tas_lock_monitor`

## Requirements
- R1: After reset every memory word reads zero, and done and busy are low on both ports.
- R2: A plain op (code 00 read, 01 write, 11 read) is accepted when req is high on an idle port. Done pulses in the next cycle with rdata equal to the word's value before the op. A write stores wdata at the accepting edge.
- R3: A test-and-set (op code 10) accepted at a clock edge raises done exactly three cycles later, for one cycle only.
- R4: A test-and-set returns the word's old value in rdata during its done cycle, whether or not it stores.
- R5: A test-and-set writes its wdata only when the old value is zero. Otherwise the word is left unchanged.
- R6: While one port holds a word for a test-and-set, a test-and-set from the other port to that word gets busy in that cycle and is not accepted. After the release, a retry is accepted.
- R7: When both ports request a test-and-set to the same word in the same cycle, port 0 is accepted and port 1 sees busy.
- R8: Test-and-set requests to different words proceed on both ports at once with no busy.
- R9: Plain reads never see busy and complete while the other port holds a word, including the held word.
- R10: When both ports write the same word at the same edge, port 0's value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears state and memory |
| p0_req | input | 1 | Port 0 request, sampled when idle |
| p0_op | input | 2 | Port 0 operation: 00 read, 01 write, 10 test-and-set, 11 read |
| p0_addr | input | 6 | Port 0 word address |
| p0_wdata | input | 32 | Port 0 write / owner value |
| p0_rdata | output | 32 | Port 0 returned old value, valid with done |
| p0_done | output | 1 | Port 0 one-cycle completion pulse |
| p0_busy | output | 1 | Port 0 test-and-set refused, retry |
| p1_req | input | 1 | Port 1 request, sampled when idle |
| p1_op | input | 2 | Port 1 operation, same coding as port 0 |
| p1_addr | input | 6 | Port 1 word address |
| p1_wdata | input | 32 | Port 1 write / owner value |
| p1_rdata | output | 32 | Port 1 returned old value, valid with done |
| p1_done | output | 1 | Port 1 one-cycle completion pulse |
| p1_busy | output | 1 | Port 1 test-and-set refused, retry |

## Verification
The test-and-set is driven in five patterns:
- alone on a zero word and on a non-zero word, which separates the store from the skip;
- against a word already held, which exercises the lock itself;
- against a same-cycle rival on the same word, which exposes the fixed priority;
- in parallel on different words, which shows that the lock is per address and not global;
- alongside a plain read of the held word, which shows that plain traffic bypasses the lock.

A scoreboard pairs every done pulse with the old value the model predicts, so a missing, extra or late completion shows up as well as a wrong value.

// File: rtl/tas_pkg.sv
package tas_pkg;

  localparam int unsigned NPORT = 2;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_TAS   = 2'b10,
    OP_RSVD  = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PDONE,
    ST_RD,
    ST_CMP,
    ST_WR
  } st_e;

endpackage

// File: rtl/tas_mem.sv
module tas_mem #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned DW    = 32,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0][AW-1:0]  ra,
  output logic [1:0][DW-1:0]  rd,
  input  logic [1:0]          wen,
  input  logic [1:0][AW-1:0]  wa,
  input  logic [1:0][DW-1:0]  wd
);

  logic [DW-1:0] mem_q [DEPTH];

  // port 1 is applied first so that port 0 lands last on a same-word clash
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
    end else begin
      if (wen[1]) mem_q[wa[1]] <= wd[1];
      if (wen[0]) mem_q[wa[0]] <= wd[0];
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_rd
    assign rd[p] = mem_q[ra[p]];
  end

  // R10: both ports writing one word leaves port 0's data
  p_wr_prio_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wen[0] && wen[1] && wa[0] == wa[1]) |=> (mem_q[$past(wa[0])] == $past(wd[0])));

endmodule

// File: rtl/tas_lock_arbiter.sv
module tas_lock_arbiter
  import tas_pkg::*;
#(
  parameter int unsigned AW = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          req,
  input  logic [1:0][1:0]     op,
  input  logic [1:0][AW-1:0]  addr,
  input  logic [1:0]          idle,
  input  logic [1:0]          hold,
  input  logic [1:0][AW-1:0]  hold_addr,
  output logic [1:0]          grant,
  output logic [1:0]          busy
);

  logic [1:0] want;
  logic [1:0] conflict;
  logic       tie_same;

  for (genvar p = 0; p < 2; p++) begin : g_want
    assign want[p] = req[p] && idle[p] && (op[p] == OP_TAS);
  end

  assign tie_same = want[0] && want[1] && (addr[0] == addr[1]);

  for (genvar p = 0; p < 2; p++) begin : g_arb
    localparam int unsigned Q = 1 - p;
    logic held_by_other;
    assign held_by_other = hold[Q] && (hold_addr[Q] == addr[p]);
    // fixed priority: port 0 beats port 1 on a same-cycle tie
    assign conflict[p] = held_by_other || ((p == 1) && tie_same);
    assign busy[p]     = want[p] && conflict[p];
    assign grant[p]    = want[p] && !conflict[p];

    // R6: a refused port must have been asking for a test-and-set
    p_busy_needs_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy[p] |-> (req[p] && op[p] == OP_TAS));
  end

  // R7: on a tie with nothing held, port 0 is granted and port 1 refused
  p_tie_port0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tie_same && !hold[0] && !hold[1]) |-> (grant[0] && busy[1]));

  // R8: distinct words never refuse each other when nothing is held
  p_distinct_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (want[0] && want[1] && addr[0] != addr[1] && !hold[0] && !hold[1]) |-> (busy == 2'b00));

endmodule

// File: rtl/tas_port_engine.sv
module tas_port_engine
  import tas_pkg::*;
#(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [1:0]    op,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          grant,
  output logic [AW-1:0] mem_ra,
  input  logic [DW-1:0] mem_rd,
  output logic          mem_we,
  output logic [AW-1:0] mem_wa,
  output logic [DW-1:0] mem_wd,
  output logic          idle,
  output logic          hold,
  output logic [AW-1:0] hold_addr,
  output logic          done,
  output logic [DW-1:0] rdata
);

  function automatic logic word_is_free(input logic [DW-1:0] v);
    return (v == '0);
  endfunction

  st_e           st_q, st_d;
  logic [AW-1:0] lk_addr_q;
  logic [DW-1:0] val_q;
  logic [DW-1:0] data_q;
  logic          store_q;

  logic accept, plain_read, plain_write, tas_accept, store_commit;

  assign accept       = req && (st_q == ST_IDLE);
  assign plain_write  = accept && (op == OP_WRITE);
  assign plain_read   = accept && (op == OP_READ || op == OP_RSVD);
  assign tas_accept   = accept && (op == OP_TAS) && grant;
  assign store_commit = (st_q == ST_WR) && store_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (plain_read || plain_write) st_d = ST_PDONE;
                else if (tas_accept)           st_d = ST_RD;
      ST_PDONE: st_d = ST_IDLE;
      ST_RD:    st_d = ST_CMP;
      ST_CMP:   st_d = ST_WR;
      ST_WR:    st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      lk_addr_q <= '0;
      val_q     <= '0;
      data_q    <= '0;
      store_q   <= 1'b0;
    end else begin
      st_q <= st_d;
      if (plain_read || plain_write) data_q <= mem_rd;
      if (tas_accept) begin
        lk_addr_q <= addr;
        val_q     <= wdata;
      end
      if (st_q == ST_RD)  data_q  <= mem_rd;
      if (st_q == ST_CMP) store_q <= word_is_free(data_q);
    end
  end

  assign mem_ra    = (st_q == ST_IDLE) ? addr : lk_addr_q;
  assign mem_we    = plain_write || store_commit;
  assign mem_wa    = (st_q == ST_WR) ? lk_addr_q : addr;
  assign mem_wd    = (st_q == ST_WR) ? val_q : wdata;
  assign idle      = (st_q == ST_IDLE);
  assign hold      = (st_q == ST_RD) || (st_q == ST_CMP) || (st_q == ST_WR);
  assign hold_addr = lk_addr_q;
  assign done      = (st_q == ST_PDONE) || (st_q == ST_WR);
  assign rdata     = data_q;

  // R3: fixed three-cycle latency from acceptance to done
  p_tas_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tas_accept |-> ##3 done);

  // R3: done is a single-cycle pulse
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5: a store commits only if the word read two cycles earlier was zero
  p_store_on_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    store_commit |-> ($past(mem_rd, 2) == '0));

  // R4: the value handed back is the word read at the read step
  p_old_returned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WR) |-> (rdata == $past(mem_rd, 2)));

endmodule

// File: rtl/tas_lock_monitor.sv
module tas_lock_monitor
  import tas_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned DW    = 32,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          p0_req,
  input  logic [1:0]    p0_op,
  input  logic [AW-1:0] p0_addr,
  input  logic [DW-1:0] p0_wdata,
  output logic [DW-1:0] p0_rdata,
  output logic          p0_done,
  output logic          p0_busy,
  input  logic          p1_req,
  input  logic [1:0]    p1_op,
  input  logic [AW-1:0] p1_addr,
  input  logic [DW-1:0] p1_wdata,
  output logic [DW-1:0] p1_rdata,
  output logic          p1_done,
  output logic          p1_busy
);

  logic [1:0]          req_v, grant_v, busy_v, idle_v, hold_v, done_v, we_v;
  logic [1:0][1:0]     op_v;
  logic [1:0][AW-1:0]  addr_v, hold_addr_v, ra_v, wa_v;
  logic [1:0][DW-1:0]  wdata_v, rdata_v, rd_v, wd_v;

  assign req_v   = {p1_req, p0_req};
  assign op_v    = {p1_op, p0_op};
  assign addr_v  = {p1_addr, p0_addr};
  assign wdata_v = {p1_wdata, p0_wdata};

  tas_lock_arbiter #(.AW(AW)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(req_v), .op(op_v), .addr(addr_v),
    .idle(idle_v), .hold(hold_v), .hold_addr(hold_addr_v),
    .grant(grant_v), .busy(busy_v)
  );

  for (genvar p = 0; p < int'(NPORT); p++) begin : g_port
    tas_port_engine #(.AW(AW), .DW(DW)) u_eng (
      .clk(clk), .rst_n(rst_n), .req(req_v[p]), .op(op_v[p]),
      .addr(addr_v[p]), .wdata(wdata_v[p]), .grant(grant_v[p]),
      .mem_ra(ra_v[p]), .mem_rd(rd_v[p]), .mem_we(we_v[p]),
      .mem_wa(wa_v[p]), .mem_wd(wd_v[p]), .idle(idle_v[p]),
      .hold(hold_v[p]), .hold_addr(hold_addr_v[p]),
      .done(done_v[p]), .rdata(rdata_v[p])
    );
  end

  tas_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
    .clk(clk), .rst_n(rst_n), .ra(ra_v), .rd(rd_v),
    .wen(we_v), .wa(wa_v), .wd(wd_v)
  );

  assign p0_rdata = rdata_v[0];
  assign p0_done  = done_v[0];
  assign p0_busy  = busy_v[0];
  assign p1_rdata = rdata_v[1];
  assign p1_done  = done_v[1];
  assign p1_busy  = busy_v[1];

  // R6: the two ports never hold the same word at once
  p_lock_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(hold_v[0] && hold_v[1] && hold_addr_v[0] == hold_addr_v[1]));

  // R9: plain requests are never refused
  p_plain_not_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (p1_req && p1_op != OP_TAS) |-> !p1_busy);

endmodule

// File: tb/tas_lock_monitor_bench.sv
module tas_lock_monitor_bench;
  localparam int DW = 32;
  localparam int AW = 6;
  localparam logic [1:0] RD = 2'b00, WR = 2'b01, TS = 2'b10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          req [2];
  logic [1:0]    op [2];
  logic [AW-1:0] addr [2];
  logic [DW-1:0] wd [2];
  logic [DW-1:0] rdata [2];
  logic          done [2];
  logic          busy [2];

  tas_lock_monitor u_tas_lock_monitor (
    .clk(clk), .rst_n(rst_n),
    .p0_req(req[0]), .p0_op(op[0]), .p0_addr(addr[0]), .p0_wdata(wd[0]),
    .p0_rdata(rdata[0]), .p0_done(done[0]), .p0_busy(busy[0]),
    .p1_req(req[1]), .p1_op(op[1]), .p1_addr(addr[1]), .p1_wdata(wd[1]),
    .p1_rdata(rdata[1]), .p1_done(done[1]), .p1_busy(busy[1])
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic [DW-1:0] exp_q0 [$];
  logic [DW-1:0] exp_q1 [$];
  string tag_q0 [$];
  string tag_q1 [$];

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic push(input int p, input logic [DW-1:0] d, input string tag);
    if (p == 0) begin exp_q0.push_back(d); tag_q0.push_back(tag); end
    else        begin exp_q1.push_back(d); tag_q1.push_back(tag); end
  endtask

  task automatic drive(input int p, input logic [1:0] o, input logic [AW-1:0] a, input logic [DW-1:0] w);
    req[p] = 1'b1; op[p] = o; addr[p] = a; wd[p] = w;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // monitor: every done pulse is matched against the next predicted old value
  always @(negedge clk) begin
    if (rst_n) begin
      if (done[0]) begin
        if (exp_q0.size() == 0) chk(1'b0, "R3 p0 unexpected done", {31'b0, done[0]}, '0);
        else chk(rdata[0] == exp_q0[0], tag_q0[0], rdata[0], exp_q0[0]);
        if (exp_q0.size() != 0) begin void'(exp_q0.pop_front()); void'(tag_q0.pop_front()); end
      end
      if (done[1]) begin
        if (exp_q1.size() == 0) chk(1'b0, "R3 p1 unexpected done", {31'b0, done[1]}, '0);
        else chk(rdata[1] == exp_q1[0], tag_q1[0], rdata[1], exp_q1[0]);
        if (exp_q1.size() != 0) begin void'(exp_q1.pop_front()); void'(tag_q1.pop_front()); end
      end
    end
  end

  // one operation on one port, with latency checks
  task automatic single(input int p, input logic [1:0] o, input logic [AW-1:0] a,
                        input logic [DW-1:0] w, input logic [DW-1:0] e, input string tag);
    drive(p, o, a, w);
    #1 chk(busy[p] == 1'b0, {tag, " busy"}, {31'b0, busy[p]}, '0);
    push(p, e, tag);
    tick();
    req[p] = 1'b0;
    if (o == TS) begin
      chk(done[p] == 1'b0, "R3 early done", {31'b0, done[p]}, '0);
      @(negedge clk);
      @(negedge clk);
      chk(done[p] == 1'b1, "R3 done at third cycle", {31'b0, done[p]}, 32'd1);
      @(negedge clk);
      chk(done[p] == 1'b0, "R3 done pulse width", {31'b0, done[p]}, '0);
    end else begin
      chk(done[p] == 1'b1, {tag, " plain done"}, {31'b0, done[p]}, 32'd1);
      @(negedge clk);
      chk(done[p] == 1'b0, {tag, " plain pulse"}, {31'b0, done[p]}, '0);
    end
  endtask

  bit finished = 1'b0;

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R3 watchdog actual=hung expected=complete");
      summary();
    end
  end

  initial begin
    for (int p = 0; p < 2; p++) begin
      req[p] = 1'b0; op[p] = RD; addr[p] = '0; wd[p] = '0;
    end
    repeat (3) @(negedge clk);
    chk(done[0] == 0 && done[1] == 0, "R1 done low in reset", {30'b0, done[1], done[0]}, '0);
    chk(busy[0] == 0 && busy[1] == 0, "R1 busy low in reset", {30'b0, busy[1], busy[0]}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: memory cleared
    single(0, RD, 6'd0, '0, 32'h0, "R1 word0");
    single(1, RD, 6'd63, '0, 32'h0, "R1 word63");

    // R2: plain write then read, write returns prior value
    single(0, WR, 6'd3, 32'h1234, 32'h0, "R2 write");
    single(1, RD, 6'd3, '0, 32'h1234, "R2 read");
    single(1, WR, 6'd3, 32'h5678, 32'h1234, "R2 overwrite");
    single(0, 2'b11, 6'd3, '0, 32'h5678, "R2 code11 read");

    // R4/R5: store on zero word, skip on non-zero word
    single(0, TS, 6'd4, 32'hCAFE, 32'h0, "R4 tas zero");
    single(1, TS, 6'd4, 32'hBEEF, 32'hCAFE, "R5 tas nonzero");
    single(0, RD, 6'd4, '0, 32'hCAFE, "R5 unchanged");

    // R6: held word refuses the other port
    drive(0, TS, 6'd5, 32'hA);
    #1 chk(busy[0] == 1'b0, "R6 owner busy", {31'b0, busy[0]}, '0);
    push(0, 32'h0, "R6 owner old");
    tick();
    req[0] = 1'b0;
    drive(1, TS, 6'd5, 32'hB);
    #1 chk(busy[1] == 1'b1, "R6 loser busy", {31'b0, busy[1]}, 32'd1);
    tick();
    req[1] = 1'b0;
    chk(done[1] == 1'b0, "R6 refused not done", {31'b0, done[1]}, '0);
    @(negedge clk);
    @(negedge clk);
    single(1, TS, 6'd5, 32'hB, 32'hA, "R6 retry");
    single(0, RD, 6'd5, '0, 32'hA, "R6 value");

    // R7: same-cycle tie on one word
    drive(0, TS, 6'd9, 32'h11);
    drive(1, TS, 6'd9, 32'h22);
    #1 chk(busy[0] == 1'b0, "R7 p0 busy", {31'b0, busy[0]}, '0);
    chk(busy[1] == 1'b1, "R7 p1 busy", {31'b0, busy[1]}, 32'd1);
    push(0, 32'h0, "R7 winner old");
    tick();
    req[0] = 1'b0; req[1] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(done[0] == 1'b1 && done[1] == 1'b0, "R7 done pattern", {30'b0, done[1], done[0]}, 32'd1);
    @(negedge clk);
    single(1, RD, 6'd9, '0, 32'h11, "R7 winner value");

    // R8: different words in parallel
    drive(0, TS, 6'd10, 32'h1);
    drive(1, TS, 6'd11, 32'h2);
    #1 chk(busy[0] == 1'b0 && busy[1] == 1'b0, "R8 no busy", {30'b0, busy[1], busy[0]}, '0);
    push(0, 32'h0, "R8 p0 old");
    push(1, 32'h0, "R8 p1 old");
    tick();
    req[0] = 1'b0; req[1] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(done[0] == 1'b1 && done[1] == 1'b1, "R8 both done", {30'b0, done[1], done[0]}, 32'd3);
    @(negedge clk);
    single(0, RD, 6'd11, '0, 32'h2, "R8 p1 stored");

    // R9: plain read of a held word
    drive(0, TS, 6'd20, 32'h7);
    push(0, 32'h0, "R9 owner old");
    tick();
    req[0] = 1'b0;
    drive(1, RD, 6'd20, '0);
    #1 chk(busy[1] == 1'b0, "R9 read not busy", {31'b0, busy[1]}, '0);
    push(1, 32'h0, "R9 read during hold");
    tick();
    req[1] = 1'b0;
    chk(done[1] == 1'b1, "R9 read done during hold", {31'b0, done[1]}, 32'd1);
    @(negedge clk);
    @(negedge clk);

    // R10: same-edge writes to one word
    drive(0, WR, 6'd30, 32'h77);
    drive(1, WR, 6'd30, 32'h88);
    push(0, 32'h0, "R10 p0 old");
    push(1, 32'h0, "R10 p1 old");
    tick();
    req[0] = 1'b0; req[1] = 1'b0;
    @(negedge clk);
    single(1, RD, 6'd30, '0, 32'h77, "R10 port0 kept");

    repeat (2) @(negedge clk);
    chk(exp_q0.size() == 0 && exp_q1.size() == 0, "R3 all completions seen",
        exp_q0.size() + exp_q1.size(), '0);
    finished = 1'b1;
    summary();
  end

endmodule